// File: doc/BRIEF.md
# Reduced two-wire bus controller register front end

This block is the software-visible face of a two-wire serial bus master. A processor reaches it through a plain 32-bit register port with one-cycle writes and combinational reads. Through it, software sets up the bus clock, picks a target register and device, loads write data and a command byte, and then launches a transfer. A separate serial engine shifts the bits on the wire. This front end passes that engine its configuration and one-cycle control strobes. When the engine finishes, it reports back a completion, an error indication with the failing byte and a negative-acknowledge marker, and any read data.

The block keeps the busy state itself. A new start that arrives while a transfer or the bus initialization sequence is still running is refused and recorded as a load-busy event. It supports aborting a running transfer and a self-timed soft reset. It keeps sticky completion and error flags that software clears by writing ones. It drives one interrupt line from those flags, masked per flag and by a global enable. Software can also take direct control of the data and clock wires and read back their live levels.

Top module: `twb_front`

## Requirements
- R1: After reset every register reads zero, except the two live line levels in line control bits 4 (data wire) and 5 (clock wire). The irq output and all engine strobes are low.
- R2: Fields read back as written and drive the engine outputs. The clock register (0x04) holds the divider in bits 7:0 and the data-out delay in bits 10:8. Register address (0x10) and command (0x2C) each hold bits 7:0. Device address (0x30) holds the runtime address in bits 23:16 and the hardware address in bits 15:0. Data (0x1C) holds all 32 bits. Unused bits and unmapped offsets read zero.
- R3: Writing control (0x00) with bit 7 set and bit 6 clear while idle gives exactly one cycle of eng_start. Control bit 7 then reads 1 until the engine reports done.
- R4: A done without failure ends the transfer, clears control bit 7 and sets status (0x0C) bit 0.
- R5: A done with failure sets status bit 1, copies eng_fail_byte into status bits 11:8 and eng_nack into status bit 16, and leaves bit 0 clear.
- R6: A successful done with eng_has_rdata loads the data register with eng_rdata right-aligned and masked by eng_rd_len: 0 keeps one byte, 1 keeps two bytes, 2 or 3 keeps four bytes.
- R7: A start request while a transfer or an initialization is running sets status bit 2. It produces no eng_start, and the running operation carries on.
- R8: Writing control bit 6 during a transfer clears busy at the next edge and gives one cycle of eng_abort. It sets no status flag, and a later done from the engine is ignored.
- R9: Writing 1 to status bit 0, 1 or 2 clears that flag. Clearing bit 1 also clears bits 11:8 and 16. Writing 0 changes nothing. A flag-setting event in the same cycle wins over the clear.
- R10: irq = control bit 1 AND (OR over status bits 2:0 masked by interrupt-enable (0x08) bits 2:0).
- R11: Writing control bit 0 starts a soft reset. For SRST_CYCLES cycles control bit 0 reads 1 and eng_abort is held high. All registers then read their reset values, and control bit 0 returns to 0.
- R12: Writing device mode (0x28) with bit 31 set while idle gives one cycle of eng_init_start. Bit 31 then reads 1 until eng_init_done. Bits 23:0 are stored and driven on eng_init_cfg. A bit-31 write during a transfer starts nothing.
- R13: Line control (0x24) bits 0 to 3 drive line_sda_oe, line_sda_val, line_scl_oe and line_scl_val. Bits 4 and 5 read line_sda_in and line_scl_in live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_abort | output | 1 | Abort strobe, held during soft reset |
| eng_init_start | output | 1 | One-cycle bus initialization launch |
| eng_cmd | output | 8 | Command byte |
| eng_rt_addr | output | 8 | Runtime device address |
| eng_hw_addr | output | 16 | Hardware device address |
| eng_reg_addr | output | 8 | Target register address |
| eng_wdata | output | 32 | Write data for the engine |
| eng_clk_div | output | 8 | Bus clock divider |
| eng_sda_delay | output | 3 | Data-out delay |
| eng_init_cfg | output | 24 | Initialization sequence settings |
| eng_done | input | 1 | Transfer finished (one cycle) |
| eng_fail | input | 1 | Finished transfer failed |
| eng_nack | input | 1 | Failure was a missing acknowledge |
| eng_fail_byte | input | 4 | Failing data byte identifier |
| eng_has_rdata | input | 1 | eng_rdata carries read data |
| eng_rd_len | input | 2 | Read width code |
| eng_rdata | input | 32 | Read data |
| eng_init_done | input | 1 | Initialization finished |
| line_sda_in | input | 1 | Live data wire level |
| line_scl_in | input | 1 | Live clock wire level |
| line_sda_oe | output | 1 | Software override enable, data wire |
| line_sda_val | output | 1 | Override value, data wire |
| line_scl_oe | output | 1 | Software override enable, clock wire |
| line_scl_val | output | 1 | Override value, clock wire |

## Verification
The main loop runs a table of transfers through the bench's own engine model. The table covers reads of one, two and four bytes plus the spare width code, a plain write, a data-byte failure and an acknowledge failure. Together these separate the width masking, the choice between capturing and keeping the data register, and the encoding of the error fields. Directed cases then cover the timing-sensitive paths. These are a start while busy with a transfer or with initialization, an abort followed by a late completion, a clear that lands on the same edge as a flag being set, and the interrupt gating through both mask levels. A soft reset issued in mid-transfer is also covered.

// File: rtl/twb_pkg.sv
package twb_pkg;

    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int CMD_W  = 8;
    localparam int HWA_W  = 16;
    localparam int ICFG_W = 24;

    localparam logic [AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [AW-1:0] OFS_CLK   = 8'h04;
    localparam logic [AW-1:0] OFS_IEN   = 8'h08;
    localparam logic [AW-1:0] OFS_ISTS  = 8'h0C;
    localparam logic [AW-1:0] OFS_RADDR = 8'h10;
    localparam logic [AW-1:0] OFS_DATA  = 8'h1C;
    localparam logic [AW-1:0] OFS_LINE  = 8'h24;
    localparam logic [AW-1:0] OFS_DMODE = 8'h28;
    localparam logic [AW-1:0] OFS_CMD   = 8'h2C;
    localparam logic [AW-1:0] OFS_DADDR = 8'h30;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_CLK, SEL_IEN, SEL_ISTS, SEL_RADDR,
        SEL_DATA, SEL_LINE, SEL_DMODE, SEL_CMD, SEL_DADDR
    } reg_sel_e;

    typedef struct packed {
        logic          we;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } reg_wr_t;

    // events from the transfer sequencer to the status flags
    typedef struct packed {
        logic ok;
        logic fail;
        logic lbusy;
    } xfer_evt_t;

    typedef struct packed {
        logic [3:0] byte_id;
        logic       nack;
    } fail_info_t;

    typedef struct packed {
        logic              gie;
        logic [2:0]        sda_dly;
        logic [7:0]        clk_div;
        logic [2:0]        ien;
        logic [7:0]        raddr;
        logic [DW-1:0]     data;
        logic [3:0]        line;
        logic [ICFG_W-1:0] init_cfg;
        logic [CMD_W-1:0]  cmd;
        logic [7:0]        rt;
        logic [HWA_W-1:0]  hw;
    } cfg_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_CLK:   return SEL_CLK;
            OFS_IEN:   return SEL_IEN;
            OFS_ISTS:  return SEL_ISTS;
            OFS_RADDR: return SEL_RADDR;
            OFS_DATA:  return SEL_DATA;
            OFS_LINE:  return SEL_LINE;
            OFS_DMODE: return SEL_DMODE;
            OFS_CMD:   return SEL_CMD;
            OFS_DADDR: return SEL_DADDR;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] rd_mask(input logic [1:0] len);
        case (len)
            2'd0:    return {{(DW-8){1'b0}}, 8'hFF};
            2'd1:    return {{(DW-16){1'b0}}, 16'hFFFF};
            default: return {DW{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/twb_xfer_ctrl.sv
module twb_xfer_ctrl
    import twb_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_we,
    input  logic      wr_start_bit,
    input  logic      wr_abort_bit,
    input  logic      wr_srst_bit,
    input  logic      dmode_go,
    input  logic      eng_done,
    input  logic      eng_fail,
    input  logic      eng_init_done,
    output logic      busy_q,
    output logic      init_busy_q,
    output logic      srst_active,
    output logic      start_pulse,
    output logic      abort_pulse,
    output logic      init_pulse,
    output logic      start_req,
    output logic      abort_evt,
    output xfer_evt_t evt
);

    localparam int CW = $clog2(SRST_CYCLES + 1);

    logic [CW-1:0] srst_cnt;
    logic          wr_srst;
    logic          any_busy;
    logic          accept_start;
    logic          accept_init;
    logic          done_ok;

    assign srst_active  = (srst_cnt != '0);
    assign wr_srst      = ctrl_we & wr_srst_bit;
    assign any_busy     = busy_q | init_busy_q;
    // abort bit in the same write overrides start
    assign start_req    = ctrl_we & wr_start_bit & ~wr_abort_bit & ~wr_srst;
    assign abort_evt    = ctrl_we & wr_abort_bit & ~wr_srst & busy_q;
    assign accept_start = start_req & ~any_busy;
    assign accept_init  = dmode_go & ~any_busy;
    assign done_ok      = busy_q & eng_done & ~abort_evt;

    assign evt.ok    = done_ok & ~eng_fail;
    assign evt.fail  = done_ok & eng_fail;
    assign evt.lbusy = start_req & any_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_cnt <= '0;
        end else if (wr_srst) begin
            srst_cnt <= CW'(SRST_CYCLES);
        end else if (srst_active) begin
            srst_cnt <= srst_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst_active) begin
            busy_q      <= 1'b0;
            init_busy_q <= 1'b0;
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            init_pulse  <= 1'b0;
        end else begin
            start_pulse <= accept_start;
            abort_pulse <= abort_evt;
            init_pulse  <= accept_init;
            if (accept_start) begin
                busy_q <= 1'b1;
            end else if (done_ok || abort_evt) begin
                busy_q <= 1'b0;
            end
            if (accept_init) begin
                init_busy_q <= 1'b1;
            end else if (eng_init_done) begin
                init_busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twb_irq_status.sv
module twb_irq_status
    import twb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          sts_we,
    input  logic [3:0]    w1c,      // {bit16, bit2, bit1, bit0} of the write
    input  xfer_evt_t     evt,
    input  fail_info_t    info,
    input  logic          gie,
    input  logic [2:0]    ien,
    output logic [DW-1:0] sts_word,
    output logic          sts_over,
    output logic          sts_err,
    output logic          sts_lbusy,
    output logic          irq
);

    fail_info_t err_info;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sts_over  <= 1'b0;
            sts_err   <= 1'b0;
            sts_lbusy <= 1'b0;
            err_info  <= '0;
        end else begin
            if (evt.ok) begin
                sts_over <= 1'b1;
            end else if (sts_we && w1c[0]) begin
                sts_over <= 1'b0;
            end

            if (evt.lbusy) begin
                sts_lbusy <= 1'b1;
            end else if (sts_we && w1c[2]) begin
                sts_lbusy <= 1'b0;
            end

            if (evt.fail) begin
                sts_err  <= 1'b1;
                err_info <= info;
            end else if (sts_we && w1c[1]) begin
                sts_err  <= 1'b0;
                err_info <= '0;
            end else if (sts_we && w1c[3]) begin
                err_info.nack <= 1'b0;
            end
        end
    end

    assign sts_word = {15'd0, err_info.nack, 4'd0, err_info.byte_id,
                       5'd0, sts_lbusy, sts_err, sts_over};

    assign irq = gie & |({sts_lbusy, sts_err, sts_over} & ien);

endmodule

// File: rtl/twb_cfg_regs.sv
module twb_cfg_regs
    import twb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  reg_wr_t       wr,
    input  logic          cap_rdata,
    input  logic [1:0]    rd_len,
    input  logic [DW-1:0] rdata_in,
    output cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cfg <= '0;
        end else begin
            if (wr.we) begin
                case (wr.sel)
                    SEL_CTRL:  cfg.gie                    <= wr.data[1];
                    SEL_CLK:   {cfg.sda_dly, cfg.clk_div} <= wr.data[10:0];
                    SEL_IEN:   cfg.ien                    <= wr.data[2:0];
                    SEL_RADDR: cfg.raddr                  <= wr.data[7:0];
                    SEL_DATA:  cfg.data                   <= wr.data;
                    SEL_LINE:  cfg.line                   <= wr.data[3:0];
                    SEL_DMODE: cfg.init_cfg               <= wr.data[ICFG_W-1:0];
                    SEL_CMD:   cfg.cmd                    <= wr.data[CMD_W-1:0];
                    SEL_DADDR: {cfg.rt, cfg.hw}           <= wr.data[23:0];
                    default: ;
                endcase
            end
            // engine read result takes precedence over a same-cycle bus write
            if (cap_rdata) begin
                cfg.data <= rdata_in & rd_mask(rd_len);
            end
        end
    end

endmodule

// File: rtl/twb_front.sv
module twb_front
    import twb_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic              eng_abort,
    output logic              eng_init_start,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic [7:0]        eng_rt_addr,
    output logic [HWA_W-1:0]  eng_hw_addr,
    output logic [7:0]        eng_reg_addr,
    output logic [DW-1:0]     eng_wdata,
    output logic [7:0]        eng_clk_div,
    output logic [2:0]        eng_sda_delay,
    output logic [ICFG_W-1:0] eng_init_cfg,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              eng_nack,
    input  logic [3:0]        eng_fail_byte,
    input  logic              eng_has_rdata,
    input  logic [1:0]        eng_rd_len,
    input  logic [DW-1:0]     eng_rdata,
    input  logic              eng_init_done,
    input  logic              line_sda_in,
    input  logic              line_scl_in,
    output logic              line_sda_oe,
    output logic              line_sda_val,
    output logic              line_scl_oe,
    output logic              line_scl_val
);

    reg_sel_e   rsel;
    reg_wr_t    wr;
    cfg_t       cfg;
    xfer_evt_t  evt;
    fail_info_t info;
    logic       busy_q, init_busy_q, srst_active;
    logic       start_pulse, abort_pulse, init_pulse;
    logic       start_req, abort_evt;
    logic       sts_over, sts_err, sts_lbusy;
    logic [DW-1:0] sts_word;

    assign rsel    = decode(bus_addr);
    assign wr.we   = bus_valid & bus_write & ~srst_active;
    assign wr.sel  = rsel;
    assign wr.data = bus_wdata;

    assign info.byte_id = eng_fail_byte;
    assign info.nack    = eng_nack;

    twb_xfer_ctrl #(.SRST_CYCLES(SRST_CYCLES)) u_xfer (
        .clk           (clk),
        .rst           (rst),
        .ctrl_we       (wr.we && wr.sel == SEL_CTRL),
        .wr_start_bit  (wr.data[7]),
        .wr_abort_bit  (wr.data[6]),
        .wr_srst_bit   (wr.data[0]),
        .dmode_go      (wr.we && wr.sel == SEL_DMODE && wr.data[31]),
        .eng_done      (eng_done),
        .eng_fail      (eng_fail),
        .eng_init_done (eng_init_done),
        .busy_q        (busy_q),
        .init_busy_q   (init_busy_q),
        .srst_active   (srst_active),
        .start_pulse   (start_pulse),
        .abort_pulse   (abort_pulse),
        .init_pulse    (init_pulse),
        .start_req     (start_req),
        .abort_evt     (abort_evt),
        .evt           (evt)
    );

    twb_irq_status u_sts (
        .clk       (clk),
        .rst       (rst),
        .clr       (srst_active),
        .sts_we    (wr.we && wr.sel == SEL_ISTS),
        .w1c       ({wr.data[16], wr.data[2:0]}),
        .evt       (evt),
        .info      (info),
        .gie       (cfg.gie),
        .ien       (cfg.ien),
        .sts_word  (sts_word),
        .sts_over  (sts_over),
        .sts_err   (sts_err),
        .sts_lbusy (sts_lbusy),
        .irq       (irq)
    );

    twb_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .clr       (srst_active),
        .wr        (wr),
        .cap_rdata (evt.ok & eng_has_rdata),
        .rd_len    (eng_rd_len),
        .rdata_in  (eng_rdata),
        .cfg       (cfg)
    );

    assign eng_start      = start_pulse;
    assign eng_abort      = abort_pulse | srst_active;
    assign eng_init_start = init_pulse;
    assign eng_cmd        = cfg.cmd;
    assign eng_rt_addr    = cfg.rt;
    assign eng_hw_addr    = cfg.hw;
    assign eng_reg_addr   = cfg.raddr;
    assign eng_wdata      = cfg.data;
    assign eng_clk_div    = cfg.clk_div;
    assign eng_sda_delay  = cfg.sda_dly;
    assign eng_init_cfg   = cfg.init_cfg;
    assign line_sda_oe    = cfg.line[0];
    assign line_sda_val   = cfg.line[1];
    assign line_scl_oe    = cfg.line[2];
    assign line_scl_val   = cfg.line[3];

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            SEL_CTRL:  bus_rdata = {24'd0, busy_q, 5'd0, cfg.gie, srst_active};
            SEL_CLK:   bus_rdata = {21'd0, cfg.sda_dly, cfg.clk_div};
            SEL_IEN:   bus_rdata = {29'd0, cfg.ien};
            SEL_ISTS:  bus_rdata = sts_word;
            SEL_RADDR: bus_rdata = {24'd0, cfg.raddr};
            SEL_DATA:  bus_rdata = cfg.data;
            SEL_LINE:  bus_rdata = {26'd0, line_scl_in, line_sda_in, cfg.line};
            SEL_DMODE: bus_rdata = {init_busy_q, 7'd0, cfg.init_cfg};
            SEL_CMD:   bus_rdata = {24'd0, cfg.cmd};
            SEL_DADDR: bus_rdata = {8'd0, cfg.rt, cfg.hw};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/twb_front_chk.sv
module twb_front_chk (
    input logic clk,
    input logic rst,
    input logic eng_start,
    input logic eng_abort,
    input logic eng_init_start,
    input logic eng_done,
    input logic eng_fail,
    input logic irq,
    input logic gie,
    input logic busy_q,
    input logic init_busy_q,
    input logic srst_active,
    input logic start_req,
    input logic abort_evt,
    input logic sts_over,
    input logic sts_err,
    input logic sts_lbusy
);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy_q);

    // R12
    launch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(eng_start && eng_init_start));

    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && eng_done && !eng_fail && !abort_evt && !srst_active |=> sts_over && !busy_q);

    // R7
    load_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_req && (busy_q || init_busy_q) && !srst_active |=> sts_lbusy && !eng_start);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort_evt |=> !busy_q && eng_abort);

    // R8
    abort_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        abort_evt && !sts_over |=> !sts_over);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

    // R11
    srst_abort_chk: assert property (@(posedge clk) disable iff (rst)
        srst_active |-> eng_abort);

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst_active |=> !busy_q && !sts_err && !sts_lbusy);

endmodule

bind twb_front twb_front_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .eng_start      (eng_start),
    .eng_abort      (eng_abort),
    .eng_init_start (eng_init_start),
    .eng_done       (eng_done),
    .eng_fail       (eng_fail),
    .irq            (irq),
    .gie            (cfg.gie),
    .busy_q         (busy_q),
    .init_busy_q    (init_busy_q),
    .srst_active    (srst_active),
    .start_req      (start_req),
    .abort_evt      (abort_evt),
    .sts_over       (sts_over),
    .sts_err        (sts_err),
    .sts_lbusy      (sts_lbusy)
);

// File: tb/twb_front_tb.sv
module twb_front_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SRST       = 4;

    localparam logic [7:0] A_CTRL = 8'h00, A_CLK = 8'h04, A_IEN = 8'h08,
                           A_STS = 8'h0C, A_RADDR = 8'h10, A_DATA = 8'h1C,
                           A_LINE = 8'h24, A_DMODE = 8'h28, A_CMD = 8'h2C,
                           A_DADDR = 8'h30;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  raddr;
        logic        fail;
        logic        nack;
        logic [3:0]  fbyte;
        logic        has;
        logic [1:0]  len;
        logic [31:0] rdata;
        logic [31:0] wdata;
        logic [31:0] exp_sts;
        logic [31:0] exp_data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'h11, 8'h20, 1'b0, 1'b0, 4'h0, 1'b1, 2'd0, 32'hA5C3_7E19, 32'h0, 32'h1, 32'h0000_0019},
        '{8'h12, 8'h21, 1'b0, 1'b0, 4'h0, 1'b1, 2'd1, 32'h1234_BEEF, 32'h0, 32'h1, 32'h0000_BEEF},
        '{8'h13, 8'h22, 1'b0, 1'b0, 4'h0, 1'b1, 2'd2, 32'hCAFE_F00D, 32'h0, 32'h1, 32'hCAFE_F00D},
        '{8'h14, 8'h23, 1'b0, 1'b0, 4'h0, 1'b1, 2'd3, 32'h0F0E_0D0C, 32'h0, 32'h1, 32'h0F0E_0D0C},
        '{8'h21, 8'h24, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h5566_7788, 32'h1, 32'h5566_7788},
        '{8'h22, 8'h25, 1'b1, 1'b0, 4'h3, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0042, 32'h302, 32'h0000_0042},
        '{8'h23, 8'h26, 1'b1, 1'b1, 4'h0, 1'b0, 2'd0, 32'h0, 32'h0000_0099, 32'h1_0002, 32'h0000_0099}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_abort, eng_init_start;
    logic [7:0]  eng_cmd, eng_rt_addr, eng_reg_addr, eng_clk_div;
    logic [15:0] eng_hw_addr;
    logic [31:0] eng_wdata;
    logic [2:0]  eng_sda_delay;
    logic [23:0] eng_init_cfg;
    logic        eng_done = 1'b0, eng_fail = 1'b0, eng_nack = 1'b0;
    logic [3:0]  eng_fail_byte = '0;
    logic        eng_has_rdata = 1'b0;
    logic [1:0]  eng_rd_len = '0;
    logic [31:0] eng_rdata = '0;
    logic        eng_init_done = 1'b0;
    logic        line_sda_in = 1'b1, line_scl_in = 1'b0;
    logic        line_sda_oe, line_sda_val, line_scl_oe, line_scl_val;

    int tests = 0;
    int fails = 0;
    int n_start = 0, n_abort = 0, n_init = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (eng_start)      n_start <= n_start + 1;
        if (eng_abort)      n_abort <= n_abort + 1;
        if (eng_init_start) n_init  <= n_init + 1;
    end

    twb_front #(.SRST_CYCLES(SRST)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_init_start(eng_init_start), .eng_cmd(eng_cmd),
        .eng_rt_addr(eng_rt_addr), .eng_hw_addr(eng_hw_addr),
        .eng_reg_addr(eng_reg_addr), .eng_wdata(eng_wdata),
        .eng_clk_div(eng_clk_div), .eng_sda_delay(eng_sda_delay),
        .eng_init_cfg(eng_init_cfg), .eng_done(eng_done), .eng_fail(eng_fail),
        .eng_nack(eng_nack), .eng_fail_byte(eng_fail_byte),
        .eng_has_rdata(eng_has_rdata), .eng_rd_len(eng_rd_len),
        .eng_rdata(eng_rdata), .eng_init_done(eng_init_done),
        .line_sda_in(line_sda_in), .line_scl_in(line_scl_in),
        .line_sda_oe(line_sda_oe), .line_sda_val(line_sda_val),
        .line_scl_oe(line_scl_oe), .line_scl_val(line_scl_val)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic reply(input logic f, input logic n, input logic [3:0] fb,
                         input logic h, input logic [1:0] l, input logic [31:0] rd);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = f; eng_nack = n; eng_fail_byte = fb;
        eng_has_rdata = h; eng_rd_len = l; eng_rdata = rd;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0; eng_nack = 1'b0; eng_has_rdata = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int s0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        br(A_CTRL, r);  check("R1 ctrl", r, 32'h0);
        br(A_CLK, r);   check("R1 clk", r, 32'h0);
        br(A_STS, r);   check("R1 status", r, 32'h0);
        br(A_DATA, r);  check("R1 data", r, 32'h0);
        br(A_DMODE, r); check("R1 dmode", r, 32'h0);
        br(A_DADDR, r); check("R1 daddr", r, 32'h0);
        br(A_LINE, r);  check("R1 line live bits", r, 32'h10);
        check("R1 outputs", {28'd0, irq, eng_start, eng_abort, eng_init_start}, 32'h0);

        // R2 configuration readback and engine outputs
        bw(A_CLK, 32'hFFFF_FFFF);
        br(A_CLK, r); check("R2 clk readback", r, 32'h7FF);
        check("R2 clk outputs", {21'd0, eng_sda_delay, eng_clk_div}, 32'h7FF);
        bw(A_RADDR, 32'h1234);
        br(A_RADDR, r); check("R2 raddr", r, 32'h34);
        bw(A_CMD, 32'hABCD);
        br(A_CMD, r); check("R2 cmd", {r[15:0], 8'd0, eng_cmd}, 32'h00CD_00CD);
        bw(A_DADDR, 32'hFFFF_FFFF);
        br(A_DADDR, r); check("R2 daddr", r, 32'h00FF_FFFF);
        check("R2 addr outputs", {eng_rt_addr, eng_hw_addr, eng_reg_addr}, 32'hFFFF_FF34);
        br(8'h14, r); check("R2 unmapped", r, 32'h0);

        // R13 line override and live readback
        bw(A_LINE, 32'h3F);
        check("R13 line outputs", {28'd0, line_scl_val, line_scl_oe, line_sda_val, line_sda_oe}, 32'hF);
        line_sda_in = 1'b0; line_scl_in = 1'b1;
        br(A_LINE, r); check("R13 line read", r, 32'h2F);
        bw(A_LINE, 32'h0);

        // R3..R6, R9 table of transfers
        for (int i = 0; i < NV; i++) begin
            bw(A_DATA, VEC[i].wdata);
            bw(A_CMD, {24'd0, VEC[i].cmd});
            bw(A_RADDR, {24'd0, VEC[i].raddr});
            s0 = n_start;
            bw(A_CTRL, 32'h80);
            br(A_CTRL, r); check($sformatf("R3 busy vec%0d", i), r, 32'h80);
            check($sformatf("R2 eng fields vec%0d", i), {eng_cmd, eng_reg_addr, 16'd0},
                  {VEC[i].cmd, VEC[i].raddr, 16'd0});
            reply(VEC[i].fail, VEC[i].nack, VEC[i].fbyte, VEC[i].has, VEC[i].len, VEC[i].rdata);
            check($sformatf("R3 one start vec%0d", i), n_start - s0, 1);
            br(A_CTRL, r); check($sformatf("R4 idle vec%0d", i), r, 32'h0);
            br(A_STS, r); check($sformatf("R4/R5 status vec%0d", i), r, VEC[i].exp_sts);
            br(A_DATA, r); check($sformatf("R6 data vec%0d", i), r, VEC[i].exp_data);
            bw(A_STS, 32'hFFFF_FFFF);
            br(A_STS, r); check($sformatf("R9 clear vec%0d", i), r, 32'h0);
        end

        // R9 write zero keeps, clearing bit 16 alone keeps bit 1, set wins over clear
        bw(A_CTRL, 32'h80);
        reply(1'b1, 1'b1, 4'h5, 1'b0, 2'd0, 32'h0);
        bw(A_STS, 32'h0);
        br(A_STS, r); check("R9 zero write", r, 32'h1_0502);
        bw(A_STS, 32'h1_0000);
        br(A_STS, r); check("R9 nack clear", r, 32'h502);
        bw(A_STS, 32'h2);
        br(A_STS, r); check("R9 err clear", r, 32'h0);
        bw(A_CTRL, 32'h80);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_STS; bus_wdata = 32'h1;
        eng_done = 1'b1; eng_fail = 1'b0; eng_has_rdata = 1'b0;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; eng_done = 1'b0;
        br(A_STS, r); check("R9 set wins", r, 32'h1);

        // R10 interrupt gating
        bw(A_IEN, 32'h1);
        check("R10 no gie", {31'd0, irq}, 32'h0);
        bw(A_CTRL, 32'h2);
        check("R10 gie and enable", {31'd0, irq}, 32'h1);
        bw(A_IEN, 32'h6);
        check("R10 masked", {31'd0, irq}, 32'h0);
        bw(A_STS, 32'h7);
        bw(A_IEN, 32'h0);
        bw(A_CTRL, 32'h0);

        // R7 start while transfer running
        s0 = n_start;
        bw(A_CTRL, 32'h80);
        bw(A_CTRL, 32'h80);
        br(A_STS, r); check("R7 load busy flag", r, 32'h4);
        br(A_CTRL, r); check("R7 still busy", r, 32'h80);
        reply(1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h0);
        check("R7 single start", n_start - s0, 1);
        br(A_STS, r); check("R7 transfer completes", r, 32'h5);
        bw(A_STS, 32'h7);

        // R8 abort then late completion
        bw(A_DATA, 32'h777);
        bw(A_CTRL, 32'h80);
        s0 = n_abort;
        bw(A_CTRL, 32'h40);
        check("R8 abort strobe", {31'd0, eng_abort}, 32'h1);
        br(A_CTRL, r); check("R8 idle after abort", r, 32'h0);
        reply(1'b0, 1'b0, 4'h0, 1'b1, 2'd2, 32'hDEAD_BEEF);
        check("R8 abort count", n_abort - s0, 1);
        br(A_STS, r); check("R8 no flag", r, 32'h0);
        br(A_DATA, r); check("R8 late data ignored", r, 32'h777);

        // R12 initialization sequence
        s0 = n_init;
        bw(A_DMODE, 32'h8012_3456);
        br(A_DMODE, r); check("R12 init running", r, 32'h8012_3456);
        check("R12 init cfg out", {8'd0, eng_init_cfg}, 32'h0012_3456);
        bw(A_CTRL, 32'h80);
        br(A_STS, r); check("R7 start during init", r, 32'h4);
        br(A_CTRL, r); check("R7 no transfer during init", r, 32'h0);
        @(negedge clk) eng_init_done = 1'b1;
        @(negedge clk) eng_init_done = 1'b0;
        check("R12 one init strobe", n_init - s0, 1);
        br(A_DMODE, r); check("R12 init done", r, 32'h0012_3456);
        bw(A_STS, 32'h7);
        bw(A_CTRL, 32'h80);
        bw(A_DMODE, 32'h8000_0000);
        br(A_DMODE, r); check("R12 init blocked while busy", r, 32'h0);
        reply(1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 32'h0);
        check("R12 no init strobe while busy", n_init - s0, 1);
        bw(A_STS, 32'h7);

        // R11 soft reset in the middle of a transfer
        bw(A_CLK, 32'h55);
        bw(A_CTRL, 32'h82);
        bw(A_CTRL, 32'h01);
        br(A_CTRL, r); check("R11 reset bit reads one", {31'd0, r[0]}, 32'h1);
        check("R11 abort held", {31'd0, eng_abort}, 32'h1);
        repeat (SRST + 2) @(negedge clk);
        br(A_CTRL, r); check("R11 reset bit clears", r, 32'h0);
        br(A_CLK, r); check("R11 registers cleared", r, 32'h0);
        br(A_DMODE, r); check("R11 dmode cleared", r, 32'h0);
        check("R11 abort released", {31'd0, eng_abort}, 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule